// File: doc/BRIEF.md
# Latched One-of-N Address Decoder

This block turns a binary select address into a one-of-N active-low select bus. The default is a 3-bit address and eight outputs. An address hold control lets the surrounding logic freeze the address. While the hold control is low, the decoder follows the live select inputs. On the cycle the hold control rises, the address that was present is kept. From then on, activity on the select lines has no effect on the outputs until the hold drops again. Bus systems that place an address once and then let the lines move on can use this to get a selection that does not glitch.

Two output enables gate the whole bus. One is active high and one is active low. Both must be asserted for any output to go low. They act apart from the address path, so turning the outputs off and on again leaves the held address intact. The held address lives in a clocked register that loads every cycle the hold is low. A bypass multiplexer makes the path look transparent. The outputs are combinational from that effective address and the enables, with no added latency.

Top module: `addr_hold_decoder`

## Requirements
- R1: After synchronous reset, the stored address is 0. If hold is raised with no prior low cycle, sel_n_o shows output 0 low (8'hFE) when both enables are asserted.
- R2: While hold is low and the enables are asserted, exactly one bit of sel_n_o is 0, in the same cycle. Its index is the live addr_i value, where addr_i[2] is the most significant bit and addr_i[0] the least.
- R3: The address present on addr_i in the last clock cycle that hold was low is the one retained once hold is high.
- R4: While hold stays high, changes on addr_i do not change sel_n_o. The retained address is decoded.
- R5: sel_n_o is all ones unless en_hi_i is 1 and en_lo_n_i is 0 together.
- R6: Toggling the enables while hold is high does not alter the retained address. Once the enables are asserted again, the same output is low.
- R7: When hold returns low, decoding follows the live addr_i again in the same cycle.
- R8: At no time are two or more bits of sel_n_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Select address |
| hold_i | input | 1 | Address hold; low = follow, high = retain |
| en_hi_i | input | 1 | Active-high output enable |
| en_lo_n_i | input | 1 | Active-low output enable |
| sel_n_o | output | 8 | One-hot-low select outputs |

## Verification
The bench builds the block with its default width of three address bits. At that width every address can be swept against every enable pair, and every pair of held and disturbing addresses can be tried. Expected outputs come from arithmetic: the value ~(1 << index), or all ones when disabled. That makes the full address-by-address space and every combination of hold and enables reachable in a few hundred cycles.

// File: rtl/ahd_pkg.sv
package ahd_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned OUT_N  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OUT_N-1:0]  sel_t;

    typedef struct packed {
        logic hi;
        logic lo_n;
    } enables_t;

    function automatic logic enables_on(input enables_t e);
        return e.hi & ~e.lo_n;
    endfunction

    function automatic sel_t onehot_low(input addr_t a);
        sel_t v;
        v = '1;
        v[a] = 1'b0;
        return v;
    endfunction
endpackage

// File: rtl/ahd_addr_hold.sv
module ahd_addr_hold
    import ahd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t addr_i,
    input  logic  hold_i,
    output addr_t eff_o
);
    addr_t kept_q;

    always_ff @(posedge clk) begin
        if (rst)
            kept_q <= '0;
        else if (!hold_i)
            kept_q <= addr_i;
    end

    assign eff_o = hold_i ? kept_q : addr_i;
endmodule

// File: rtl/ahd_decode.sv
module ahd_decode
    import ahd_pkg::*;
(
    input  addr_t addr_i,
    output sel_t  onehot_n_o
);
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign onehot_n_o[i] = (addr_i != addr_t'(i));
    end
endmodule

// File: rtl/ahd_gate.sv
module ahd_gate
    import ahd_pkg::*;
(
    input  sel_t     raw_n_i,
    input  enables_t en_i,
    output sel_t     sel_n_o
);
    always_comb begin
        sel_n_o = enables_on(en_i) ? raw_n_i : '1;
    end
endmodule

// File: rtl/addr_hold_decoder.sv
module addr_hold_decoder
    import ahd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  addr_i,
    input  logic        hold_i,
    input  logic        en_hi_i,
    input  logic        en_lo_n_i,
    output logic [7:0]  sel_n_o
);
    addr_t    eff;
    sel_t     raw_n;
    enables_t en;

    assign en.hi   = en_hi_i;
    assign en.lo_n = en_lo_n_i;

    ahd_addr_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr_i),
        .hold_i (hold_i),
        .eff_o  (eff)
    );

    ahd_decode u_dec (
        .addr_i     (eff),
        .onehot_n_o (raw_n)
    );

    ahd_gate u_gate (
        .raw_n_i (raw_n),
        .en_i    (en),
        .sel_n_o (sel_n_o)
    );
endmodule

module addr_hold_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] addr_i,
    input logic       hold_i,
    input logic       en_hi_i,
    input logic       en_lo_n_i,
    input logic [7:0] sel_n_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R8
    p_at_most_one_low_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(~sel_n_o) <= 1);

    // R5
    p_disabled_high_r5: assert property (@(posedge clk) disable iff (rst)
        !(en_hi_i && !en_lo_n_i) |-> (sel_n_o == 8'hFF));

    // R2
    p_follow_live_r2: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && en_hi_i && !en_lo_n_i) |-> (sel_n_o[addr_i] == 1'b0));

    // R4
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && hold_i && $past(hold_i) && en_hi_i && !en_lo_n_i
         && $past(en_hi_i) && !$past(en_lo_n_i)) |-> $stable(sel_n_o));

    // R3
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && hold_i && !$past(hold_i) && en_hi_i && !en_lo_n_i)
        |-> (sel_n_o[$past(addr_i)] == 1'b0));

    // R5: enabled means exactly one low
    p_enabled_one_low_r5: assert property (@(posedge clk) disable iff (rst)
        (en_hi_i && !en_lo_n_i) |-> ($countones(~sel_n_o) == 1));
endmodule

bind addr_hold_decoder addr_hold_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_i),
    .hold_i    (hold_i),
    .en_hi_i   (en_hi_i),
    .en_lo_n_i (en_lo_n_i),
    .sel_n_o   (sel_n_o)
);

// File: tb/sim_addr_hold_decoder.sv
module sim_addr_hold_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr_i = '0;
    logic       hold_i = 1'b0;
    logic       en_hi_i = 1'b0;
    logic       en_lo_n_i = 1'b1;
    logic [7:0] sel_n_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #5 clk = ~clk;

    addr_hold_decoder u0 (
        .clk(clk), .rst(rst), .addr_i(addr_i), .hold_i(hold_i),
        .en_hi_i(en_hi_i), .en_lo_n_i(en_lo_n_i), .sel_n_o(sel_n_o)
    );

    function automatic logic [7:0] expect_sel(input int idx, input logic hi, input logic lo_n);
        if (hi && !lo_n) return ~(8'd1 << idx);
        return 8'hFF;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        compared++;
        if (sel_n_o !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", req, sel_n_o, exp);
        end
    endtask

    // drive on negedge, let combinational settle, sample
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        hold_i = 1'b1;
        step(); step();
        rst = 1'b0;
        #1;
        // R1: reset state, hold high from the start
        check("R1 reset disabled", 8'hFF);
        en_hi_i = 1'b1; en_lo_n_i = 1'b0; addr_i = 3'd5;
        #1 check("R1 reset addr 0", 8'hFE);
        step();
        check("R1 reset addr 0 kept", 8'hFE);

        // R2 + R5 sweep: transparent mode, all addrs x enables
        hold_i = 1'b0;
        for (int a = 0; a < 8; a++) begin
            for (int e = 0; e < 4; e++) begin
                addr_i = 3'(a); en_hi_i = e[1]; en_lo_n_i = e[0];
                #1 check("R2/R5 live decode", expect_sel(a, e[1], e[0]));
            end
        end
        step();

        // R3/R4/R6/R7: every held x disturbing address
        for (int h = 0; h < 8; h++) begin
            en_hi_i = 1'b1; en_lo_n_i = 1'b0;
            hold_i = 1'b0; addr_i = 3'(h);
            step();
            hold_i = 1'b1;
            #1 check("R3 capture", expect_sel(h, 1, 0));
            for (int d = 0; d < 8; d++) begin
                addr_i = 3'(d);
                step();
                check("R4 ignore select while held", expect_sel(h, 1, 0));
            end
            en_hi_i = 1'b0; step();
            check("R5 disabled while held", 8'hFF);
            en_hi_i = 1'b1; en_lo_n_i = 1'b1; step();
            check("R5 lo_n high while held", 8'hFF);
            en_lo_n_i = 1'b0; step();
            check("R6 enables restore held addr", expect_sel(h, 1, 0));
            addr_i = 3'((h + 3) % 8);
            hold_i = 1'b0;
            #1 check("R7 resume live decode", expect_sel((h + 3) % 8, 1, 0));
            step();
        end

        // R8: one low in any enabled live state
        for (int a = 0; a < 8; a++) begin
            addr_i = 3'(a); #1;
            compared++;
            if ($countones(~sel_n_o) != 1) begin
                mismatched++;
                $display("FAIL R8: got %0d lows expected 1", $countones(~sel_n_o));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule